// File: doc/BRIEF.md
# Register Lock FIFO Scoreboard

This block tracks pending register writes for a pipeline whose results come back in the same order the instructions were issued. Each issued instruction that writes a register deposits a decoded destination into a small queue. The decoded destination is a row with a single set bit in that register's column. When a result returns, the oldest row leaves the queue, and the block reports which register that result belongs to.

A register counts as locked when any stored row has its column set. The block answers this question for a source register with one OR gate per column. It does not compare register numbers across pipeline stages. The decode stage presents a source register number and holds the instruction while the stall output is high. A register that appears in several pending rows stays locked until the last of those rows has left the queue.

Top module: `reglock_scoreboard`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `wb_valid`, `full` and `src_stall` are all 0 for every source number, because reset empties every stage.
- R2: A push is accepted when `iss_valid`=1 and `full`=0. It stores a row whose only set bit is at position `iss_dst`. The register locks from the cycle after the push edge. In the push cycle itself, `src_stall` for that register still reflects the older entries only.
- R3: A cycle with `iss_valid`=0 adds no entry. This models an instruction with no destination register, and the `iss_dst` value in that cycle leaves no lock.
- R4: `src_stall` is 1 exactly when the register numbered `src_reg` is set in at least one stored row. It is 0 for every register that no stored row names.
- R5: `wb_valid` is 1 whenever at least one entry is stored. `wb_reg` gives the register number (binary, `REG_W` bits) of the oldest entry, in push order. `wb_reg` is 0 when the queue is empty.
- R6: When the same register is pushed more than once, it stays locked until every entry naming it has been popped.
- R7: `full` is 1 when all `DEPTH` stages hold an entry. A push attempted while `full`=1 is dropped, even if a pop happens in the same cycle.
- R8: `wb_pop` while `wb_valid`=0 has no effect.
- R9: An accepted push and a valid pop in the same cycle both take effect. The oldest entry leaves, the new entry joins at the tail, and the number of stored entries does not change.
- R10: When the only entry naming a register is popped, that register unlocks from the cycle after the pop edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An issued instruction writes the register `iss_dst` |
| iss_dst | input | REG_W | Destination register number of the issued instruction |
| full | output | 1 | All stages are occupied; pushes are refused |
| wb_pop | input | 1 | A result has returned; remove the oldest entry |
| wb_valid | output | 1 | At least one pending write is stored |
| wb_reg | output | REG_W | Register number of the oldest pending write |
| src_reg | input | REG_W | Source register number to look up |
| src_stall | output | 1 | The looked-up register has a pending write |

## Verification
The bench builds the block with its default values: 16 register columns and 4 stages. At that depth, a short table of vectors can fill the queue completely. It then tries a push while full, both alone and together with a pop. After that it drains the queue to empty and pops once more. Sixteen columns make the lowest and highest register numbers (0 and 15) reachable. The same table also covers a register held by two entries at once, and a push and pop in the same cycle, both at depth one and at full depth.

// File: rtl/regscb_pkg.sv
`timescale 1ns/1ps
package regscb_pkg;

    // Default geometry of the scoreboard
    localparam int DEF_NUM_REGS = 16;
    localparam int DEF_DEPTH    = 4;

    // Operation applied to the row store on one clock edge
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PUSH = 2'b01,
        ST_POP  = 2'b10,
        ST_BOTH = 2'b11
    } store_op_e;

    // Occupancy summary of the row store
    typedef struct packed {
        logic full;
        logic empty;
    } occ_t;

    function automatic store_op_e pick_op(input logic do_push, input logic do_pop);
        return store_op_e'({do_pop, do_push});
    endfunction

endpackage

// File: rtl/rl_fifo_store.sv
`timescale 1ns/1ps
module rl_fifo_store
    import regscb_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DEPTH    = DEF_DEPTH
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               push_req,
    input  logic [NUM_REGS-1:0]                push_row,
    input  logic                               pop_req,
    output logic [DEPTH-1:0][NUM_REGS-1:0]     rows,
    output logic [NUM_REGS-1:0]                head_row,
    output occ_t                               occ
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;
    store_op_e        op;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign occ.full  = (count == FULL_CNT);
    assign occ.empty = (count == '0);

    // A push is refused whenever every stage is taken, pop or not
    assign do_push = push_req && !occ.full;
    assign do_pop  = pop_req  && !occ.empty;
    assign op      = pick_op(do_push, do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            rows   <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (op)
                ST_PUSH: begin
                    rows[wr_ptr] <= push_row;
                    wr_ptr       <= adv(wr_ptr);
                    count        <= count + 1'b1;
                end
                ST_POP: begin
                    rows[rd_ptr] <= '0;
                    rd_ptr       <= adv(rd_ptr);
                    count        <= count - 1'b1;
                end
                ST_BOTH: begin
                    // Not full, so write and read stages differ
                    rows[rd_ptr] <= '0;
                    rows[wr_ptr] <= push_row;
                    rd_ptr       <= adv(rd_ptr);
                    wr_ptr       <= adv(wr_ptr);
                end
                default: ;
            endcase
        end
    end

    assign head_row = rows[rd_ptr];

endmodule

// File: rtl/rl_column_or.sv
`timescale 1ns/1ps
module rl_column_or
    import regscb_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DEPTH    = DEF_DEPTH
) (
    input  logic [DEPTH-1:0][NUM_REGS-1:0] rows,
    output logic [NUM_REGS-1:0]            lock_vec
);

    // Empty stages hold zeros, so every stage may join the OR
    for (genvar c = 0; c < NUM_REGS; c++) begin : g_col
        logic [DEPTH-1:0] column;
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            assign column[s] = rows[s][c];
        end
        assign lock_vec[c] = |column;
    end

endmodule

// File: rtl/rl_onehot_enc.sv
`timescale 1ns/1ps
module rl_onehot_enc
    import regscb_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] onehot,
    output logic [REG_W-1:0]    index
);

    always_comb begin
        index = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            index = index | (onehot[i] ? REG_W'(i) : '0);
        end
    end

endmodule

// File: rtl/reglock_scoreboard.sv
`timescale 1ns/1ps
module reglock_scoreboard
    import regscb_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DEPTH    = DEF_DEPTH,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [REG_W-1:0] iss_dst,
    output logic             full,
    input  logic             wb_pop,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_reg,
    input  logic [REG_W-1:0] src_reg,
    output logic             src_stall
);

    logic [NUM_REGS-1:0]            dst_row;
    logic [DEPTH-1:0][NUM_REGS-1:0] rows;
    logic [NUM_REGS-1:0]            head_row;
    logic [NUM_REGS-1:0]            lock_vec;
    occ_t                           occ;

    // Decode destination number into a one-hot row
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign dst_row[i] = (iss_dst == REG_W'(i));
    end

    rl_fifo_store #(
        .NUM_REGS (NUM_REGS),
        .DEPTH    (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_req (iss_valid),
        .push_row (dst_row),
        .pop_req  (wb_pop),
        .rows     (rows),
        .head_row (head_row),
        .occ      (occ)
    );

    rl_column_or #(
        .NUM_REGS (NUM_REGS),
        .DEPTH    (DEPTH)
    ) u_cols (
        .rows     (rows),
        .lock_vec (lock_vec)
    );

    rl_onehot_enc #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_enc (
        .onehot   (head_row),
        .index    (wb_reg)
    );

    assign full      = occ.full;
    assign wb_valid  = !occ.empty;
    assign src_stall = lock_vec[src_reg];

endmodule

// File: rtl/rl_checker.sv
`timescale 1ns/1ps
module rl_checker #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                iss_valid,
    input logic [REG_W-1:0]    iss_dst,
    input logic                full,
    input logic                wb_pop,
    input logic                wb_valid,
    input logic [REG_W-1:0]    wb_reg,
    input logic [REG_W-1:0]    src_reg,
    input logic                src_stall,
    input logic [NUM_REGS-1:0] head_row
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wb_valid && !full && !src_stall)); // R1

    AST_HEAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(head_row) && (wb_valid == (head_row != '0))); // R2

    AST_PUSH_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !full && !wb_pop) |=> wb_valid); // R2

    AST_NO_DEST_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid && !wb_pop) |=> ($stable(wb_valid) && $stable(full) && $stable(wb_reg))); // R3

    AST_EMPTY_NO_REG: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |-> (wb_reg == '0 && !full)); // R5

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (full && !wb_pop) |=> (full && $stable(wb_reg))); // R7

    AST_FULL_POP_DROPS_PUSH: assert property (@(posedge clk) disable iff (rst)
        (full && wb_pop) |=> !full); // R7

    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!wb_valid && !iss_valid) |=> !wb_valid); // R8

    AST_BOTH_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !full && wb_pop && wb_valid) |=> (wb_valid && !full)); // R9

    // Inputs are observed so that every port of the bound module is used
    logic unused_ok;
    assign unused_ok = ^{iss_dst, src_reg, src_stall};

endmodule

bind reglock_scoreboard rl_checker #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .full      (full),
    .wb_pop    (wb_pop),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .src_reg   (src_reg),
    .src_stall (src_stall),
    .head_row  (head_row)
);

// File: tb/reglock_scoreboard_tb.sv
`timescale 1ns/1ps
module reglock_scoreboard_tb;

    localparam int REG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             iss_valid = 1'b0;
    logic [REG_W-1:0] iss_dst = '0;
    logic             wb_pop = 1'b0;
    logic [REG_W-1:0] src_reg = '0;
    logic             full, wb_valid, src_stall;
    logic [REG_W-1:0] wb_reg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reglock_scoreboard u_dut (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .full      (full),
        .wb_pop    (wb_pop),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .src_reg   (src_reg),
        .src_stall (src_stall)
    );

    // Inputs applied for one cycle; expectations are sampled before the edge
    typedef struct packed {
        logic       iv;
        logic [3:0] dst;
        logic       pop;
        logic [3:0] src;
        logic       stall;
        logic       wbv;
        logic [3:0] wbr;
        logic       full;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 4'd3,  1'b0, 4'd3,  1'b0, 1'b0, 4'd0,  1'b0, 4'd2},  // R2 no lock in push cycle
        '{1'b1, 4'd7,  1'b0, 4'd3,  1'b1, 1'b1, 4'd3,  1'b0, 4'd4},  // R4 r3 locked
        '{1'b0, 4'd5,  1'b0, 4'd5,  1'b0, 1'b1, 4'd3,  1'b0, 4'd3},  // R3 no dest
        '{1'b0, 4'd0,  1'b0, 4'd5,  1'b0, 1'b1, 4'd3,  1'b0, 4'd3},  // R3 r5 never locked
        '{1'b1, 4'd3,  1'b0, 4'd7,  1'b1, 1'b1, 4'd3,  1'b0, 4'd4},  // R4 r7 locked
        '{1'b0, 4'd0,  1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b0, 4'd5},  // R5 oldest is r3
        '{1'b0, 4'd0,  1'b0, 4'd3,  1'b1, 1'b1, 4'd7,  1'b0, 4'd6},  // R6 second r3 holds lock
        '{1'b1, 4'd12, 1'b1, 4'd12, 1'b0, 1'b1, 4'd7,  1'b0, 4'd9},  // R9 pre-push view
        '{1'b1, 4'd9,  1'b0, 4'd7,  1'b0, 1'b1, 4'd3,  1'b0, 4'd10}, // R10 r7 unlocked
        '{1'b1, 4'd0,  1'b0, 4'd12, 1'b1, 1'b1, 4'd3,  1'b0, 4'd4},  // R4 r12 locked
        '{1'b1, 4'd5,  1'b0, 4'd5,  1'b0, 1'b1, 4'd3,  1'b1, 4'd7},  // R7 full, push dropped
        '{1'b0, 4'd0,  1'b0, 4'd5,  1'b0, 1'b1, 4'd3,  1'b1, 4'd7},  // R7 r5 absent
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 4'd3,  1'b1, 4'd4},  // R4 r0 locked
        '{1'b1, 4'd6,  1'b1, 4'd3,  1'b1, 1'b1, 4'd3,  1'b1, 4'd7},  // R7 full push+pop
        '{1'b0, 4'd0,  1'b1, 4'd6,  1'b0, 1'b1, 4'd12, 1'b0, 4'd7},  // R7 r6 dropped
        '{1'b0, 4'd0,  1'b1, 4'd3,  1'b0, 1'b1, 4'd9,  1'b0, 4'd10}, // R10 r3 free
        '{1'b0, 4'd0,  1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  1'b0, 4'd5},  // R5 last entry r0
        '{1'b0, 4'd0,  1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0, 4'd8},  // R8 pop on empty
        '{1'b1, 4'd15, 1'b0, 4'd15, 1'b0, 1'b0, 4'd0,  1'b0, 4'd8},  // R8 still empty
        '{1'b0, 4'd0,  1'b0, 4'd15, 1'b1, 1'b1, 4'd15, 1'b0, 4'd2},  // R2 r15 locks
        '{1'b1, 4'd4,  1'b1, 4'd4,  1'b0, 1'b1, 4'd15, 1'b0, 4'd9},  // R9 depth-one swap
        '{1'b0, 4'd0,  1'b0, 4'd15, 1'b0, 1'b1, 4'd4,  1'b0, 4'd9}   // R9 r4 now oldest
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "wb_valid in reset", int'(wb_valid), 0);
        check("R1", "full in reset", int'(full), 0);
        rst = 1'b0;
        for (int r = 0; r < 16; r++) begin
            src_reg = REG_W'(r);
            #0.5;
            check("R1", "stall after reset", int'(src_stall), 0);
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            iss_valid = TABLE[i].iv;
            iss_dst   = TABLE[i].dst;
            wb_pop    = TABLE[i].pop;
            src_reg   = TABLE[i].src;
            #1;
            tag = $sformatf("R%0d row%0d", TABLE[i].req, i);
            check(tag, "src_stall", int'(src_stall), int'(TABLE[i].stall));
            check(tag, "wb_valid",  int'(wb_valid),  int'(TABLE[i].wbv));
            check(tag, "wb_reg",    int'(wb_reg),    int'(TABLE[i].wbr));
            check(tag, "full",      int'(full),      int'(TABLE[i].full));
        end

        // R6: two entries for r2, lock survives the first pop
        @(negedge clk); iss_valid = 1'b1; iss_dst = 4'd2; wb_pop = 1'b1;  // pops r4
        @(negedge clk); iss_valid = 1'b1; iss_dst = 4'd2; wb_pop = 1'b0;
        @(negedge clk); iss_valid = 1'b0; wb_pop = 1'b1; src_reg = 4'd2;
        #1; check("R6", "r2 locked twice", int'(src_stall), 1);
        @(negedge clk); wb_pop = 1'b0;
        #1; check("R6", "r2 locked after one pop", int'(src_stall), 1);
        check("R5", "oldest r2", int'(wb_reg), 2);
        wb_pop = 1'b1;
        @(negedge clk); wb_pop = 1'b0;
        #1; check("R10", "r2 free after last pop", int'(src_stall), 0);
        check("R8", "empty again", int'(wb_valid), 0);

        // R1: reset with entries stored
        iss_valid = 1'b1; iss_dst = 4'd11;
        @(negedge clk); iss_dst = 4'd13;
        @(negedge clk); iss_valid = 1'b0; src_reg = 4'd11;
        #1; check("R4", "r11 locked before reset", int'(src_stall), 1);
        rst = 1'b1;
        @(negedge clk);
        #1; check("R1", "reset clears entries", int'(wb_valid), 0);
        check("R1", "reset clears r11 lock", int'(src_stall), 0);
        rst = 1'b0;
        src_reg = 4'd13;
        @(negedge clk);
        #1; check("R1", "r13 free after reset", int'(src_stall), 0);

        finish_run();
    end

endmodule